// File: doc/BRIEF.md
# Host sanity watchdog timer

This block is a countdown watchdog for a network controller that watches whether its host is still alive. It counts in quarter-second units, advancing once per pulse on a quarter-second tick input, and it only counts while its run state is set. When the count is used up it takes one of two actions, chosen by the current operating mode. In the standard modes it raises a one-cycle request to reboot the host. In the extended mode it raises a one-cycle request to leave that mode and return to the standard one, with the extended registers cleared.

The enable state has two bits. The arm bit follows a hardware or strap configuration input and is reported as an option-status bit for the vector register. The run bit is loaded from a software enable only when a setup strobe arrives while the block is armed. The period starts at a fixed hardware number of seconds times four. A load strobe carrying a host timeout in seconds replaces it with four times that value, but only while armed. A kick strobe reloads the full period while the timer runs. After expiry the counter stays stopped until a kick or a setup reloads it.

Top module: `sanity_wdog`

## Requirements
- R1: While reset is held and in the first cycle after it, reboot_req_o, mode_fallback_o and opt_status_o are 0; the run bit resets to 0 and the period resets to HW_SECS*4 quarter ticks.
- R2: opt_status_o equals the value hw_arm_i had one clock earlier.
- R3: A setup_i strobe while armed copies sw_en_i into the run bit and, if the run bit becomes 1, reloads the count with the period; a setup_i strobe while not armed leaves the run bit and count unchanged.
- R4: With the default period, after a setup that starts the timer, the expiry pulse follows the HW_SECS*4-th tick and no earlier tick.
- R5: A hit_load_i strobe while armed sets the period to 4*hit_secs_i quarter ticks; while not armed it is ignored.
- R6: Ticks with the run bit clear never decrement the count and never cause a pulse.
- R7: A kick_i strobe while running reloads the full period; when kick_i and tick_i arrive in the same cycle, the reload wins and the tick is not counted.
- R8: On expiry (the tick that brings the count to zero or below) with ext_mode_i = 0, reboot_req_o is 1 for exactly the one cycle after that tick's clock edge.
- R9: On expiry with ext_mode_i = 1, mode_fallback_o pulses for one cycle instead and reboot_req_o stays 0.
- R10: After expiry no further pulse occurs, whatever ticks arrive, until the count is reloaded by kick_i or by setup_i.
- R11: A period of zero (hit_secs_i = 0) expires on the first counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle quarter-second tick |
| hw_arm_i | input | 1 | Hardware/switch arm configuration |
| setup_i | input | 1 | Setup processing strobe |
| sw_en_i | input | 1 | Software sanity enable, sampled at setup |
| hit_load_i | input | 1 | Apply host-inactivity period strobe |
| hit_secs_i | input | SECS_W | Host timeout in seconds |
| kick_i | input | 1 | Watchdog reload strobe |
| ext_mode_i | input | 1 | 1 while in the extended mode |
| reboot_req_o | output | 1 | One-cycle host reboot request |
| mode_fallback_o | output | 1 | One-cycle extended-mode fallback request |
| opt_status_o | output | 1 | Option-status bit (armed) for the vector register |

## Verification
Directed runs count ticks to the first pulse for the default period, for a loaded host timeout and for a zero period, so an off-by-one in the reload or in the expiry compare shows up as a shifted pulse. Kicks placed in the middle of a count, and on the same cycle as a tick, separate reload priority from counting. Setup and load strobes given while disarmed tell ignored configuration apart from applied configuration. A long run with seeded random ticks, kicks, setups, loads and mode changes is compared every cycle against a bench model of the requirements, which exercises the interplay of expiry, stop-after-expiry and the choice between the two actions.

// File: rtl/sanity_pkg.sv
package sanity_pkg;
  typedef struct packed {
    logic armed;
    logic run;
  } san_en_t;
endpackage

// File: rtl/sanity_cfg.sv
module sanity_cfg #(
  parameter int SECS_W  = 8,
  parameter int CNT_W   = 16,
  parameter int HW_SECS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_arm_i,
  input  logic             setup_i,
  input  logic             sw_en_i,
  input  logic             kick_i,
  input  logic             hit_load_i,
  input  logic [SECS_W-1:0] hit_secs_i,
  output sanity_pkg::san_en_t en_o,
  output logic [CNT_W-1:0] period_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] DEF_PERIOD = CNT_W'(HW_SECS * 4);

  sanity_pkg::san_en_t en_q;
  logic [CNT_W-1:0]    period_q;
  logic                setup_ok;
  logic                run_next;

  assign setup_ok = setup_i && en_q.armed;
  assign run_next = setup_ok ? sw_en_i : en_q.run;
  assign reload_o = run_next && (setup_ok || kick_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      period_q <= DEF_PERIOD;
    end else begin
      en_q.armed <= hw_arm_i;
      en_q.run   <= run_next;
      if (hit_load_i && en_q.armed)
        period_q <= CNT_W'({hit_secs_i, 2'b00});
    end
  end

  assign en_o     = en_q;
  assign period_o = period_q;
endmodule

// File: rtl/sanity_count.sv
module sanity_count #(
  parameter int CNT_W   = 16,
  parameter int HW_SECS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] DEF_PERIOD = CNT_W'(HW_SECS * 4);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             stopped_q;
  logic             step;
  logic             last;

  assign step   = tick_i && run_i && !stopped_q && !reload_i;
  assign last   = (cnt_q <= ONE);
  assign fire_o = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= DEF_PERIOD;
      stopped_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q     <= period_i;
      stopped_q <= 1'b0;
    end else if (step) begin
      if (last) begin
        cnt_q     <= '0;
        stopped_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/sanity_action.sv
module sanity_action (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic ext_mode_i,
  output logic reboot_o,
  output logic fallback_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reboot_o   <= 1'b0;
      fallback_o <= 1'b0;
    end else begin
      reboot_o   <= fire_i && !ext_mode_i;
      fallback_o <= fire_i && ext_mode_i;
    end
  end
endmodule

// File: rtl/sanity_wdog.sv
module sanity_wdog #(
  parameter int SECS_W  = 8,
  parameter int CNT_W   = 16,
  parameter int HW_SECS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              hw_arm_i,
  input  logic              setup_i,
  input  logic              sw_en_i,
  input  logic              hit_load_i,
  input  logic [SECS_W-1:0] hit_secs_i,
  input  logic              kick_i,
  input  logic              ext_mode_i,
  output logic              reboot_req_o,
  output logic              mode_fallback_o,
  output logic              opt_status_o
);
  sanity_pkg::san_en_t en;
  logic [CNT_W-1:0]    period;
  logic                reload;
  logic                fire;

  sanity_cfg #(.SECS_W(SECS_W), .CNT_W(CNT_W), .HW_SECS(HW_SECS)) u_cfg (
    .clk(clk), .rst(rst), .hw_arm_i(hw_arm_i), .setup_i(setup_i),
    .sw_en_i(sw_en_i), .kick_i(kick_i), .hit_load_i(hit_load_i),
    .hit_secs_i(hit_secs_i), .en_o(en), .period_o(period), .reload_o(reload)
  );

  sanity_count #(.CNT_W(CNT_W), .HW_SECS(HW_SECS)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(en.run),
    .reload_i(reload), .period_i(period), .fire_o(fire)
  );

  sanity_action u_act (
    .clk(clk), .rst(rst), .fire_i(fire), .ext_mode_i(ext_mode_i),
    .reboot_o(reboot_req_o), .fallback_o(mode_fallback_o)
  );

  assign opt_status_o = en.armed;
endmodule

// File: rtl/sanity_wdog_chk.sv
module sanity_wdog_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic hw_arm_i,
  input logic ext_mode_i,
  input logic reboot_req_o,
  input logic mode_fallback_o,
  input logic opt_status_o
);
  logic seen_q;
  always_ff @(posedge clk) seen_q <= !rst;

  a_r2_opt_follows_arm: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (opt_status_o == $past(hw_arm_i)));

  a_r8_reboot_one_cycle: assert property (@(posedge clk) disable iff (rst)
    reboot_req_o |=> !reboot_req_o);

  a_r8_reboot_std_mode: assert property (@(posedge clk) disable iff (rst)
    (seen_q && reboot_req_o) |-> (!$past(ext_mode_i) && $past(tick_i)));

  a_r9_fallback_ext_mode: assert property (@(posedge clk) disable iff (rst)
    (seen_q && mode_fallback_o) |-> ($past(ext_mode_i) && $past(tick_i)));

  a_r9_actions_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(reboot_req_o && mode_fallback_o));

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> (!reboot_req_o && !mode_fallback_o && !opt_status_o));
endmodule

bind sanity_wdog sanity_wdog_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .hw_arm_i(hw_arm_i),
  .ext_mode_i(ext_mode_i), .reboot_req_o(reboot_req_o),
  .mode_fallback_o(mode_fallback_o), .opt_status_o(opt_status_o)
);

// File: tb/tb_sanity_wdog.sv
module tb_sanity_wdog;
  localparam int SECS_W  = 8;
  localparam int CNT_W   = 16;
  localparam int HW_SECS = 4;
  localparam int DEF_P   = HW_SECS * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, arm = 0, setup = 0, sw_en = 0, hl = 0, kick = 0, ext = 0;
  logic [SECS_W-1:0] secs = '0;
  logic reboot, fallback, opt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench reference state
  bit m_armed, m_run, m_stop, m_rb, m_fb;
  int m_per, m_cnt;

  always #2 clk = ~clk;

  sanity_wdog #(.SECS_W(SECS_W), .CNT_W(CNT_W), .HW_SECS(HW_SECS)) dut (
    .clk(clk), .rst(rst), .tick_i(tick), .hw_arm_i(arm), .setup_i(setup),
    .sw_en_i(sw_en), .hit_load_i(hl), .hit_secs_i(secs), .kick_i(kick),
    .ext_mode_i(ext), .reboot_req_o(reboot), .mode_fallback_o(fallback),
    .opt_status_o(opt)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_armed = 0; m_run = 0; m_stop = 0; m_rb = 0; m_fb = 0;
    m_per = DEF_P; m_cnt = DEF_P;
  endtask

  // applies the requirements for one clock edge
  task automatic model_edge();
    bit sok, rn, rl, fire;
    sok  = setup && m_armed;
    rn   = sok ? sw_en : m_run;
    rl   = rn && (sok || kick);
    fire = 0;
    if (rl) begin
      m_cnt = m_per; m_stop = 0;
    end else if (tick && m_run && !m_stop) begin
      if (m_cnt <= 1) begin m_cnt = 0; m_stop = 1; fire = 1; end
      else m_cnt = m_cnt - 1;
    end
    if (hl && m_armed) m_per = 4 * int'(secs);
    m_run   = rn;
    m_armed = arm;
    m_rb    = fire && !ext;
    m_fb    = fire && ext;
  endtask

  // one cycle: inputs set before this call are applied at the next edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R8 reboot_req", reboot, m_rb);
    check("R9 mode_fallback", fallback, m_fb);
    check("R2 opt_status", opt, m_armed);
    tick = 0; setup = 0; hl = 0; kick = 0;
  endtask

  task automatic do_setup(bit en);
    setup = 1; sw_en = en; step();
  endtask

  // ticks until a pulse is seen; returns the tick number or 0
  task automatic ticks_to_pulse(int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      tick = 1; step();
      if ((reboot || fallback) && n == 0) n = i;
      if (n != 0) break;
    end
  endtask

  initial begin
    int n;
    bit any;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1 reboot in reset", reboot, 0);
    check("R1 fallback in reset", fallback, 0);
    check("R1 opt in reset", opt, 0);
    rst = 0;
    step();

    // R6: not running, ticks do nothing
    any = 0;
    for (int i = 0; i < DEF_P + 4; i++) begin tick = 1; step(); any |= reboot | fallback; end
    check("R6 no pulse when stopped", any, 0);

    // R3/R4/R8: arm, start with default period
    arm = 1; step(); step();
    check("R2 armed status", opt, 1);
    do_setup(1);
    ticks_to_pulse(DEF_P + 4, n);
    check("R4 default period tick count", n, DEF_P);
    check("R8 reboot after expiry", m_rb, 1);

    // R10: stays stopped
    any = 0;
    for (int i = 0; i < DEF_P + 4; i++) begin tick = 1; step(); any |= reboot | fallback; end
    check("R10 no pulse after expiry", any, 0);

    // R7: kick reloads, R5 loaded period
    hl = 1; secs = 8'd2; step();
    kick = 1; step();
    for (int i = 0; i < 5; i++) begin tick = 1; step(); end
    kick = 1; tick = 1; step();   // reload wins over tick
    ticks_to_pulse(20, n);
    check("R7 R5 kick reload then 8 ticks", n, 8);

    // R9: extended mode fallback
    ext = 1; kick = 1; step();
    ticks_to_pulse(20, n);
    check("R9 fallback tick count", n, 8);
    check("R9 fallback asserted", m_fb, 1);
    ext = 0;

    // R5/R3: disarmed load and setup ignored
    arm = 0; step(); step();
    hl = 1; secs = 8'd1; step();
    do_setup(0);
    arm = 1; step(); step();
    kick = 1; step();
    ticks_to_pulse(20, n);
    check("R5 R3 disarmed strobes ignored", n, 8);

    // R3: setup with enable 0 stops
    do_setup(0);
    any = 0;
    for (int i = 0; i < 20; i++) begin tick = 1; step(); any |= reboot | fallback; end
    check("R3 setup disables run", any, 0);

    // R11: zero period
    hl = 1; secs = 8'd0; step();
    do_setup(1);
    ticks_to_pulse(4, n);
    check("R11 zero period first tick", n, 1);

    // random phase against bench model
    void'($urandom(32'h5a17));
    for (int i = 0; i < 4000; i++) begin
      tick  = ($urandom % 4) != 0;
      kick  = ($urandom % 23) == 0;
      setup = ($urandom % 41) == 0;
      sw_en = ($urandom % 5) != 0;
      hl    = ($urandom % 67) == 0;
      secs  = SECS_W'($urandom % 4);
      if (($urandom % 97) == 0) arm = ~arm;
      if (($urandom % 53) == 0) ext = ~ext;
      step();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule